// File: doc/BRIEF.md
# Swept DDS Sine Excitation Generator

This block is a direct digital synthesis source. It produces a stream of signed sine samples that drive an external load at a known frequency. A 27-bit phase accumulator adds a phase step once every fourth master clock. The ten most significant accumulator bits address a computed sine table. The output frequency is `step * (f_clk / 4) / 2^27`.

Software writes a small set of shadow registers through a write port. The generator acts on them only when a start command arrives. In constant mode it holds one phase step. In sweep mode it begins at a start step and holds each frequency point for a programmed number of divided ticks. It then adds an increment, and it stops after a programmed number of increments. A 2-bit output amplitude code is loaded at start and travels with the samples. A change of frequency never clears the accumulator, so the phase of the output stays continuous.

Top module: `swept_sine_gen`

## Requirements
- R1: While `rst` is high on a clock edge, and after it, `sample`, `phase`, `step`, `range_code`, `sample_valid`, `active` and `sweep_done` are all zero.
- R2: Before the first `start` the accumulator does not move and `sample_valid` stays low, even when registers are written.
- R3: Once `active` is high, `sample_valid` pulses for one cycle every 4 clocks, one pulse for each divided tick.
- R4: In the cycle where `sample_valid` is high, `phase` equals its previous value plus the step that was in force before that tick, modulo 2^27.
- R5: In the cycle where `sample_valid` is high, `sample` is derived from `phase[26:17]`. Let p = `phase[25:17]`. The magnitude is floor(32752·p·(512−p) / (1310720 − 4·p·(512−p))), and it is negated when `phase[26]` is 1.
- R6: In constant mode (control bit 0 = 0), `step` equals the fixed-step register from the `start` onward and never changes.
- R7: In sweep mode (control bit 0 = 1), after tick t since the start, `step` = start + inc·min(floor(t/D), N). Here N is the point-count register and D is the dwell register, with a dwell of 0 treated as 1.
- R8: `sweep_done` rises after tick (N+1)·D. From then on, `step` holds the last frequency while the accumulator keeps running, until the next `start` or reset.
- R9: A frequency change does not reset the phase: the new step applies from the tick after the one on which it was loaded.
- R10: Register map on `cfg_addr`: 0 fixed step, 1 sweep start step, 2 sweep increment, 3 point count (low 9 bits), 4 dwell ticks (low 16 bits), 5 control (bit 0 mode, bits 2:1 amplitude code). A write changes no output until the next `start`.
- R11: `range_code` equals control bits 2:1 as latched at `start`: 0 = 2 V, 1 = 1 V, 2 = 0.5 V, 3 = 0.2 V peak-to-peak.
- R12: A `start` while running reloads the program but keeps the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 27 | Register write data |
| start | input | 1 | Start command, loads the shadow registers |
| sample | output | 12 | Signed sine sample |
| sample_valid | output | 1 | One-cycle pulse per accumulator tick |
| range_code | output | 2 | Amplitude code forwarded with the samples |
| phase | output | 27 | Phase accumulator |
| step | output | 27 | Phase step currently in force |
| active | output | 1 | Excitation running |
| sweep_done | output | 1 | Final sweep point has completed |

## Verification
The hardest condition to reach is a register write that lands in the middle of a running sweep. That write must leave the step sequence, the amplitude code and the phase exactly as programmed. The bench places single writes between consecutive sample pulses, so no tick is missed, and checks every later tick against the earlier program. It then restarts and checks that the new values take effect. Restarts are aligned just after a sample pulse, so the first new tick can be predicted exactly. The check that the phase carries across the restart uses the value captured at the moment of the start.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  typedef enum logic [2:0] {
    RA_FIXED  = 3'd0,
    RA_SWBASE = 3'd1,
    RA_SWINC  = 3'd2,
    RA_SWNUM  = 3'd3,
    RA_DWELL  = 3'd4,
    RA_CTRL   = 3'd5
  } reg_addr_e;

  typedef enum logic {
    MODE_CONST = 1'b0,
    MODE_SWEEP = 1'b1
  } mode_e;

  // Rational sine approximation over a half period of `half` points,
  // scaled to peak `amp`.
  function automatic longint half_sine(input longint p, input longint half,
                                       input longint amp);
    longint u;
    u = p * (half - p);
    return (amp * 16 * u) / (5 * half * half - 4 * u);
  endfunction

endpackage

// File: rtl/ssg_clkdiv.sv
module ssg_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssg_phase_acc.sv
module ssg_phase_acc #(
  parameter int ACC_W = 27,
  parameter int TOP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase,
  output logic [TOP_W-1:0] top_nxt
);
  logic [ACC_W-1:0] nxt;

  assign nxt     = phase + inc;
  assign top_nxt = nxt[ACC_W-1 -: TOP_W];

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= nxt;
  end
endmodule

// File: rtl/ssg_sine_lut.sv
module ssg_sine_lut #(
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] data
);
  import ssg_pkg::*;

  localparam int  HALF = 1 << (AW - 1);
  localparam longint AMP = (longint'(1) << (DW - 1)) - 1;

  logic [DW-1:0] mag_rom [HALF];

  for (genvar i = 0; i < HALF; i++) begin : g_rom
    localparam logic [DW-1:0] VAL = DW'(half_sine(longint'(i), longint'(HALF), AMP));
    assign mag_rom[i] = VAL;
  end

  logic [DW-1:0] mag;
  assign mag  = mag_rom[addr[AW-2:0]];
  assign data = addr[AW-1] ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/ssg_sweep.sv
module ssg_sweep #(
  parameter int ACC_W   = 27,
  parameter int CNT_W   = 9,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               tick,
  input  logic               run,
  input  logic               cfg_sweep,
  input  logic [ACC_W-1:0]   cfg_fixed,
  input  logic [ACC_W-1:0]   cfg_base,
  input  logic [ACC_W-1:0]   cfg_inc,
  input  logic [CNT_W-1:0]   cfg_num,
  input  logic [DWELL_W-1:0] cfg_dwell,
  output logic [ACC_W-1:0]   step,
  output logic               done,
  output logic               adv_evt,
  output logic               fin_evt
);
  logic               sweep_q;
  logic [ACC_W-1:0]   inc_q;
  logic [CNT_W-1:0]   num_q;
  logic [CNT_W-1:0]   idx_q;
  logic [DWELL_W-1:0] dwell_q;
  logic [DWELL_W-1:0] dcnt_q;
  logic [DWELL_W-1:0] dwell_last;
  logic               counting;
  logic               point_end;

  assign dwell_last = (dwell_q == '0) ? '0 : dwell_q - 1'b1;
  assign counting   = tick && run && sweep_q && !done && !start;
  assign point_end  = counting && (dcnt_q == dwell_last);
  assign adv_evt    = point_end && (idx_q != num_q);
  assign fin_evt    = point_end && (idx_q == num_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_q <= 1'b0;
      inc_q   <= '0;
      num_q   <= '0;
      idx_q   <= '0;
      dwell_q <= '0;
      dcnt_q  <= '0;
      step    <= '0;
      done    <= 1'b0;
    end else if (start) begin
      sweep_q <= cfg_sweep;
      inc_q   <= cfg_inc;
      num_q   <= cfg_num;
      dwell_q <= cfg_dwell;
      idx_q   <= '0;
      dcnt_q  <= '0;
      done    <= 1'b0;
      step    <= cfg_sweep ? cfg_base : cfg_fixed;
    end else if (counting) begin
      if (point_end) begin
        dcnt_q <= '0;
        if (fin_evt) begin
          done <= 1'b1;
        end else begin
          step  <= step + inc_q;
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swept_sine_gen.sv
module swept_sine_gen #(
  parameter int ACC_W   = 27,
  parameter int LUT_AW  = 10,
  parameter int SMP_W   = 12,
  parameter int CNT_W   = 9,
  parameter int DWELL_W = 16,
  parameter int DIV     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_addr,
  input  logic [ACC_W-1:0]        cfg_wdata,
  input  logic                    start,
  output logic signed [SMP_W-1:0] sample,
  output logic                    sample_valid,
  output logic [1:0]              range_code,
  output logic [ACC_W-1:0]        phase,
  output logic [ACC_W-1:0]        step,
  output logic                    active,
  output logic                    sweep_done
);
  import ssg_pkg::*;

  // Shadow registers, loaded into the engine only on start
  logic [ACC_W-1:0]   sh_fixed, sh_base, sh_inc;
  logic [CNT_W-1:0]   sh_num;
  logic [DWELL_W-1:0] sh_dwell;
  mode_e              sh_mode;
  logic [1:0]         sh_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_fixed <= '0;
      sh_base  <= '0;
      sh_inc   <= '0;
      sh_num   <= '0;
      sh_dwell <= '0;
      sh_mode  <= MODE_CONST;
      sh_range <= '0;
    end else if (cfg_we) begin
      case (reg_addr_e'(cfg_addr))
        RA_FIXED:  sh_fixed <= cfg_wdata;
        RA_SWBASE: sh_base  <= cfg_wdata;
        RA_SWINC:  sh_inc   <= cfg_wdata;
        RA_SWNUM:  sh_num   <= cfg_wdata[CNT_W-1:0];
        RA_DWELL:  sh_dwell <= cfg_wdata[DWELL_W-1:0];
        RA_CTRL: begin
          sh_mode  <= mode_e'(cfg_wdata[0]);
          sh_range <= cfg_wdata[2:1];
        end
        default: ;
      endcase
    end
  end

  // Named internal events
  logic tick;
  logic acc_adv;
  logic adv_evt;
  logic fin_evt;
  logic [LUT_AW-1:0] lut_addr;
  logic signed [SMP_W-1:0] lut_data;

  assign acc_adv = tick && active;

  ssg_clkdiv #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  ssg_sweep #(.ACC_W(ACC_W), .CNT_W(CNT_W), .DWELL_W(DWELL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tick      (tick),
    .run       (active),
    .cfg_sweep (sh_mode == MODE_SWEEP),
    .cfg_fixed (sh_fixed),
    .cfg_base  (sh_base),
    .cfg_inc   (sh_inc),
    .cfg_num   (sh_num),
    .cfg_dwell (sh_dwell),
    .step      (step),
    .done      (sweep_done),
    .adv_evt   (adv_evt),
    .fin_evt   (fin_evt)
  );

  ssg_phase_acc #(.ACC_W(ACC_W), .TOP_W(LUT_AW)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .adv     (acc_adv),
    .inc     (step),
    .phase   (phase),
    .top_nxt (lut_addr)
  );

  ssg_sine_lut #(.AW(LUT_AW), .DW(SMP_W)) u_lut (
    .addr (lut_addr),
    .data (lut_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      range_code   <= '0;
      sample_valid <= 1'b0;
      sample       <= '0;
    end else begin
      if (start) begin
        active     <= 1'b1;
        range_code <= sh_range;
      end
      sample_valid <= acc_adv;
      if (acc_adv) sample <= lut_data;
    end
  end
endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
  parameter int ACC_W = 27
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sample_valid,
  input logic [ACC_W-1:0] phase,
  input logic [ACC_W-1:0] step,
  input logic [1:0]       range_code,
  input logic             active,
  input logic             sweep_done,
  input logic             adv_evt
);
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(phase)); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sample_valid); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid); // R3
  AST_PHASE_ADD: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> phase == ACC_W'($past(phase) + $past(step))); // R4
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv_evt && !start) |=> $stable(step)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && !start) |=> (sweep_done && $stable(step))); // R8
  AST_RANGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(range_code)); // R11
endmodule

bind swept_sine_gen ssg_checker #(.ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .sample_valid (sample_valid),
  .phase        (phase),
  .step         (step),
  .range_code   (range_code),
  .active       (active),
  .sweep_done   (sweep_done),
  .adv_evt      (adv_evt)
);

// File: tb/sim_swept_sine_gen.sv
module sim_swept_sine_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [26:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic signed [11:0] sample;
  logic        sample_valid;
  logic [1:0]  range_code;
  logic [26:0] phase;
  logic [26:0] step;
  logic        active;
  logic        sweep_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  swept_sine_gen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .sample(sample),
    .sample_valid(sample_valid), .range_code(range_code), .phase(phase),
    .step(step), .active(active), .sweep_done(sweep_done)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench copies of the program: shadow (written) and live (started)
  logic [26:0] s_fixed = 0, s_base = 0, s_inc = 0;
  int          s_num = 0, s_dwell = 0, s_mode = 0, s_range = 0;
  logic [26:0] a_fixed, a_base, a_inc;
  int          a_num, a_dwell, a_mode, a_range;
  logic [26:0] prev_phase;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic longint ref_sine(input logic [26:0] ph);
    longint p, num, den, m;
    p   = longint'(ph[25:17]);
    num = 32752 * p * (512 - p);
    den = 1310720 - 4 * p * (512 - p);
    m   = num / den;
    return ph[26] ? -m : m;
  endfunction

  // step in force for a tick count t since start (t = ticks already done)
  function automatic logic [26:0] ref_step(input int t);
    int d, k;
    if (a_mode == 0) return a_fixed;
    d = (a_dwell == 0) ? 1 : a_dwell;
    k = t / d;
    if (k > a_num) k = a_num;
    return 27'(longint'(a_base) + longint'(a_inc) * k);
  endfunction

  function automatic bit ref_done(input int t);
    int d;
    if (a_mode == 0) return 0;
    d = (a_dwell == 0) ? 1 : a_dwell;
    return t >= (a_num + 1) * d;
  endfunction

  task automatic write_reg(input int addr, input logic [26:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
    case (addr)
      0: s_fixed = data;
      1: s_base  = data;
      2: s_inc   = data;
      3: s_num   = int'(data[8:0]);
      4: s_dwell = int'(data[15:0]);
      5: begin s_mode = int'(data[0]); s_range = int'(data[2:1]); end
      default: ;
    endcase
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
    end while (!sample_valid && cyc < 40);
    if (!sample_valid) check(0, "R3 sample pulse missing", cyc, 4);
  endtask

  task automatic do_start();
    int c;
    if (active) wait_valid(c);
    @(negedge clk);
    start = 1;
    a_fixed = s_fixed; a_base = s_base; a_inc = s_inc;
    a_num = s_num; a_dwell = s_dwell; a_mode = s_mode; a_range = s_range;
    prev_phase = phase;
    @(negedge clk);
    start = 0;
  endtask

  task automatic poke(input int k);
    case (k)
      0: write_reg(0, 27'h0A0B0C0);
      1: write_reg(1, 27'h200);
      2: write_reg(2, 27'h10);
      default: write_reg(5, 27'h0);
    endcase
  endtask

  task automatic run_ticks(input int t_from, input int t_to, input int poke_at);
    int c;
    bit skip_gap;
    logic [26:0] exp_ph;
    skip_gap = 0;
    for (int t = t_from; t <= t_to; t++) begin
      wait_valid(c);
      if (t > 1 && !skip_gap) check(c == 4, "R3 tick spacing", c, 4);
      skip_gap = 0;
      exp_ph = prev_phase + ref_step(t - 1);
      check(phase == exp_ph, "R4/R9 phase advance", phase, exp_ph);
      check(sample == 12'(ref_sine(phase)), "R5 sine sample", sample, ref_sine(phase));
      check(step == ref_step(t), a_mode ? "R7 sweep step" : "R6 constant step",
            step, ref_step(t));
      check(sweep_done == ref_done(t), "R8 done flag", sweep_done, ref_done(t));
      check(range_code == 2'(a_range), "R11 range code", range_code, a_range);
      prev_phase = phase;
      if (poke_at > 0 && t >= poke_at && t < poke_at + 4) begin
        poke(t - poke_at);
        skip_gap = 1;
      end
    end
  endtask

  task automatic t_reset();
    repeat (5) @(posedge clk);
    #1;
    check(phase == 0 && step == 0 && sample == 0, "R1 reset datapath", phase, 0);
    check(!sample_valid && !active && !sweep_done && range_code == 0,
          "R1 reset flags", {sample_valid, active, sweep_done}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_idle();
    bit seen = 0;
    write_reg(0, 27'h0123457);
    write_reg(5, 27'h4);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (sample_valid) seen = 1;
    end
    check(phase == 0, "R2 no advance before start", phase, 0);
    check(!seen && !active, "R2 no samples before start", seen, 0);
    check(step == 0 && range_code == 0, "R10 write has no effect before start", step, 0);
  endtask

  task automatic t_const();
    do_start();
    run_ticks(1, 20, 0);
  endtask

  task automatic t_restart();
    logic [26:0] ph0;
    int c;
    write_reg(0, 27'h7FFFFF0);
    write_reg(5, 27'h6);
    do_start();
    ph0 = prev_phase;
    wait_valid(c);
    check(phase == 27'(ph0 + 27'h7FFFFF0), "R12 phase kept across restart",
          phase, 27'(ph0 + 27'h7FFFFF0));
    prev_phase = phase;
    run_ticks(2, 10, 0);
  endtask

  task automatic t_sweep();
    write_reg(1, 27'h100000);
    write_reg(2, 27'h040000);
    write_reg(3, 27'd3);
    write_reg(4, 27'd5);
    write_reg(5, 27'h3);
    do_start();
    run_ticks(1, 28, 0);
  endtask

  task automatic t_shadow();
    write_reg(1, 27'h3000);
    write_reg(2, 27'h1000);
    write_reg(3, 27'd4);
    write_reg(4, 27'd3);
    write_reg(5, 27'h5);
    do_start();
    run_ticks(1, 24, 6);  // R10: writes land mid-sweep
    do_start();
    check(a_mode == 0 && a_range == 0, "R10 bench program reloaded", a_mode, 0);
    run_ticks(1, 6, 0);
  endtask

  task automatic t_dwell0();
    write_reg(1, 27'h8000);
    write_reg(2, 27'h2000);
    write_reg(3, 27'd2);
    write_reg(4, 27'd0);
    write_reg(5, 27'h1);
    do_start();
    run_ticks(1, 6, 0);   // R7 dwell 0 acts as 1, R8 done after tick 3
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_const();
    t_restart();
    t_sweep();
    t_shadow();
    t_dwell0();
    finish_run();
  end
endmodule